// File: doc/BRIEF.md
# NaN Payload Format Converter

This combinational block turns a NaN held in one IEEE binary interchange width (16, 32 or 64 bits) into a NaN of another width. Sign and payload survive the trip. Internally the value passes through a canonical form: one sign bit plus a 64-bit payload field. In that field the source fraction sits left-aligned at the top and zero fill lies beneath it.

Encoding shifts the masked source word left until its fraction reaches bit 63. Decoding shifts the payload right by the destination's own amount and keeps only the destination's fraction width. It then wraps that fraction with an all-ones exponent and the carried sign. A payload that is truncated to zero must not become an infinity, so the destination's default NaN is used in that case. The same default NaN is used whenever the default-NaN mode input is high. An invalid flag reports a signaling source. The conversion does not quiet the payload itself.

Typical use is in a floating-point unit's format-conversion path, applied only once the operand has already been classified as a NaN.

Top module: `nan_payload_conv`

## Requirements
- R1: Format selects use 0 for the 16-bit format, 1 for the 32-bit format and 2 for the 64-bit format. The output always carries an all-ones exponent and a non-zero fraction for the destination format.
- R2: A conversion to a wider format keeps the sign. It places the whole source fraction at the top of the destination fraction, with zeros below it.
- R3: A conversion to a narrower format keeps the sign and the top bits of the source fraction, and drops the low bits.
- R4: If the truncated fraction is zero, the output is the destination default NaN instead of an infinity. The default NaNs are 0xFE00, 0xFFC00000 and 0xFFF8000000000000.
- R5: With default-NaN mode at 1, the output is the destination default NaN whatever the payload is.
- R6: The invalid flag is 1 exactly when the source is a signaling NaN, which means its fraction's top bit is 0. The conversion never sets that quiet bit in the output, and default-NaN mode does not mask the flag.
- R7: When the source and destination formats are equal and default-NaN mode is 0, the output equals the input.
- R8: A 16-bit or 32-bit result is zero-extended to 64 bits.
- R9: Source word bits above the source format's width have no effect.
- R10: A 16→64→16 or 32→64→32 round trip returns the original NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcWord | input | 64 | Source NaN, right-aligned for narrow formats |
| srcFmt | input | 2 | Source format select |
| dstFmt | input | 2 | Destination format select |
| defaultNanMode | input | 1 | Force the destination default NaN |
| dstWord | output | 64 | Converted NaN, zero-extended |
| invalidFlag | output | 1 | Source was a signaling NaN |

## Verification
The assertions assume that the source word is a NaN in the selected source format. They check only when the datapath itself classifies the input as a NaN, because the result for other inputs is left undefined. They also assume that format selects stay in the range 0 to 2. The stimulus drives only NaN encodings with in-range selects. Payloads are chosen to cover both quiet and signaling values, fractions that truncate to zero, and junk in the unused upper bits.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;

  localparam int WORD_W  = 64;
  localparam int NUM_FMT = 3;
  localparam int SHIFT_W = $clog2(WORD_W);
  localparam int MAX_FW  = 52;

  // fraction width per format index (0: 16-bit, 1: 32-bit, 2: 64-bit)
  function automatic int fracW(input int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic int expW(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_FMT-1:0] srcSel;
    logic [NUM_FMT-1:0] dstSel;
    logic [SHIFT_W-1:0] encShift;
    logic [SHIFT_W-1:0] decShift;
    logic               forceDefault;
    logic               passThrough;
  } convStb_t;

  typedef struct packed {
    logic              sign;
    logic [WORD_W-1:0] payload;
  } canonNan_t;

endpackage

// File: rtl/nanConvCtrl.sv
module nanConvCtrl
  import nanconv_pkg::*;
(
  input  logic [1:0] srcFmt,
  input  logic [1:0] dstFmt,
  input  logic       defaultNanMode,
  output convStb_t   stb
);

  logic [SHIFT_W-1:0] shiftTab [NUM_FMT];

  genvar g;
  generate
    for (g = 0; g < NUM_FMT; g++) begin : gShift
      assign shiftTab[g] = SHIFT_W'(WORD_W - fracW(g));
    end
  endgenerate

  function automatic int fmtIdx(input logic [1:0] sel);
    return (int'(sel) >= NUM_FMT) ? NUM_FMT - 1 : int'(sel);
  endfunction

  always_comb begin
    int si;
    int di;
    si = fmtIdx(srcFmt);
    di = fmtIdx(dstFmt);
    stb = '0;
    stb.srcSel[si]   = 1'b1;
    stb.dstSel[di]   = 1'b1;
    stb.encShift     = shiftTab[si];
    stb.decShift     = shiftTab[di];
    stb.forceDefault = defaultNanMode;
    stb.passThrough  = (si == di) && !defaultNanMode;
  end

endmodule

// File: rtl/nanConvPath.sv
module nanConvPath
  import nanconv_pkg::*;
(
  input  logic [WORD_W-1:0] srcWord,
  input  convStb_t          stb,
  output logic [WORD_W-1:0] dstWord,
  output logic              srcSignaling
);

  logic [WORD_W-1:0] maskedW [NUM_FMT];
  logic [WORD_W-1:0] candW   [NUM_FMT];
  logic [WORD_W-1:0] dfltW   [NUM_FMT];
  logic [NUM_FMT-1:0] signW, expOnesW, fracNzW, quietW, truncZeroW;

  canonNan_t         canon;
  logic [MAX_FW-1:0] fracRaw;
  logic [WORD_W-1:0] maskedSel, candSel, dfltSel;
  logic              signSel, expOnesSel, fracNzSel, quietSel, truncZeroSel;
  logic              srcIsNan;

  genvar g;
  generate
    for (g = 0; g < NUM_FMT; g++) begin : gFmt
      localparam int FW = fracW(g);
      localparam int EW = expW(g);
      localparam int TW = 1 + EW + FW;
      logic [TW-1:0] view;
      logic [FW-1:0] fracTrunc;

      // source side classification
      assign view        = srcWord[TW-1:0];
      assign maskedW[g]  = WORD_W'(view);
      assign signW[g]    = view[TW-1];
      assign expOnesW[g] = &view[TW-2:FW];
      assign fracNzW[g]  = |view[FW-1:0];
      assign quietW[g]   = view[FW-1];

      // destination side build
      assign fracTrunc     = fracRaw[FW-1:0];
      assign truncZeroW[g] = ~|fracTrunc;
      assign candW[g]      = WORD_W'({canon.sign, {EW{1'b1}}, fracTrunc});
      assign dfltW[g]      = WORD_W'({1'b1, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}});

      always_comb begin
        if (stb.dstSel[g] && srcIsNan) begin
          assert_exp_ones_R1: assert (&dstWord[TW-2:FW])
            else $error("exponent not all ones");
          assert_no_inf_R4: assert (|dstWord[FW-1:0])
            else $error("result became an infinity");
          if (stb.forceDefault) begin
            assert_default_mode_R5: assert (dstWord == dfltW[g])
              else $error("default mode ignored");
          end
          if (!stb.forceDefault && dstWord != dfltW[g]) begin
            assert_sign_kept_R2: assert (dstWord[TW-1] == signSel)
              else $error("sign lost");
            if (srcSignaling) begin
              assert_keep_quiet_bit_R6: assert (!dstWord[FW-1])
                else $error("quiet bit set by conversion");
            end
          end
        end
      end

      if (TW < WORD_W) begin : gZext
        always_comb begin
          if (stb.dstSel[g]) begin
            assert_zero_ext_R8: assert (dstWord[WORD_W-1:TW] == '0)
              else $error("upper bits not zero");
          end
        end
      end
    end
  endgenerate

  // one-hot selection of per-format values
  always_comb begin
    maskedSel = '0; candSel = '0; dfltSel = '0;
    signSel = 1'b0; expOnesSel = 1'b0; fracNzSel = 1'b0;
    quietSel = 1'b0; truncZeroSel = 1'b0;
    for (int i = 0; i < NUM_FMT; i++) begin
      if (stb.srcSel[i]) begin
        maskedSel  |= maskedW[i];
        signSel    |= signW[i];
        expOnesSel |= expOnesW[i];
        fracNzSel  |= fracNzW[i];
        quietSel   |= quietW[i];
      end
      if (stb.dstSel[i]) begin
        candSel      |= candW[i];
        dfltSel      |= dfltW[i];
        truncZeroSel |= truncZeroW[i];
      end
    end
  end

  // canonical form: payload left-aligned at bit 63
  assign canon.sign    = signSel;
  assign canon.payload = maskedSel << stb.encShift;
  assign fracRaw       = MAX_FW'(canon.payload >> stb.decShift);

  assign srcIsNan     = expOnesSel & fracNzSel;
  assign srcSignaling = srcIsNan & ~quietSel;

  always_comb begin
    if (stb.forceDefault || (!stb.passThrough && truncZeroSel))
      dstWord = dfltSel;
    else if (stb.passThrough)
      dstWord = maskedSel;
    else
      dstWord = candSel;
  end

endmodule

// File: rtl/nan_payload_conv.sv
module nan_payload_conv
  import nanconv_pkg::*;
(
  input  logic [63:0] srcWord,
  input  logic [1:0]  srcFmt,
  input  logic [1:0]  dstFmt,
  input  logic        defaultNanMode,
  output logic [63:0] dstWord,
  output logic        invalidFlag
);

  convStb_t stb;

  nanConvCtrl uCtrl (
    .srcFmt         (srcFmt),
    .dstFmt         (dstFmt),
    .defaultNanMode (defaultNanMode),
    .stb            (stb)
  );

  nanConvPath uPath (
    .srcWord      (srcWord),
    .stb          (stb),
    .dstWord      (dstWord),
    .srcSignaling (invalidFlag)
  );

endmodule

// File: tb/nan_payload_conv_test.sv
module nan_payload_conv_test;

  localparam logic [1:0] FH = 2'd0, FS = 2'd1, FD = 2'd2;

  logic        clk = 1'b0;
  logic [63:0] srcWord = '0;
  logic [1:0]  srcFmt = FH, dstFmt = FH;
  logic        defaultNanMode = 1'b0;
  logic [63:0] dstWord;
  logic        invalidFlag;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [63:0] out;
    logic        inv;
    string       tag;
  } expItem_t;
  expItem_t sb[$];

  always #5 clk = ~clk;

  nan_payload_conv uut (
    .srcWord(srcWord), .srcFmt(srcFmt), .dstFmt(dstFmt),
    .defaultNanMode(defaultNanMode), .dstWord(dstWord), .invalidFlag(invalidFlag)
  );

  task automatic apply(input logic [1:0] sf, input logic [1:0] df, input logic dm,
                       input logic [63:0] w, input logic [63:0] expOut,
                       input logic expInv, input string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    srcFmt = sf; dstFmt = df; defaultNanMode = dm; srcWord = w;
    it.out = expOut; it.inv = expInv; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare at the falling edge, away from input changes
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        expItem_t it;
        it = sb.pop_front();
        vectors++;
        if (dstWord !== it.out || invalidFlag !== it.inv) begin
          fails++;
          $display("FAIL %s: got out=%h inv=%b expected out=%h inv=%b",
                   it.tag, dstWord, invalidFlag, it.out, it.inv);
        end
      end
    end
  end

  initial begin
    // R7 same format pass, signaling input raises invalid
    apply(FH, FH, 0, 64'h0000_0000_0000_FD55, 64'h0000_0000_0000_FD55, 1, "R7 half pass");
    apply(FS, FS, 0, 64'h0000_0000_7FC1_2345, 64'h0000_0000_7FC1_2345, 0, "R7 single pass");
    apply(FD, FD, 0, 64'hFFF4_5678_9ABC_DEF0, 64'hFFF4_5678_9ABC_DEF0, 1, "R7 double pass");
    // R2 widen
    apply(FH, FS, 0, 64'h7E01, 64'h0000_0000_7FC0_2000, 0, "R2 half to single");
    apply(FH, FD, 0, 64'hFE01, 64'hFFF8_0400_0000_0000, 0, "R2 half to double");
    apply(FS, FD, 0, 64'h7FC0_0001, 64'h7FF8_0000_2000_0000, 0, "R2 single to double");
    // R3 narrow, R1 exponent build
    apply(FS, FH, 0, 64'h7FC1_2345, 64'h7E09, 0, "R3 single to half");
    apply(FD, FS, 0, 64'h7FF4_5678_9ABC_DEF0, 64'h7FA2_B3C4, 1, "R3 R6 double to single");
    apply(FD, FH, 0, 64'hFFF8_0000_0000_0000, 64'hFE00, 0, "R1 double to half");
    // R4 payload truncated to zero
    apply(FS, FH, 0, 64'h7F80_0001, 64'hFE00, 1, "R4 single to half default");
    apply(FD, FS, 0, 64'hFFF0_0000_1000_0000, 64'hFFC0_0000, 1, "R4 double to single default");
    // R5 default mode
    apply(FH, FS, 1, 64'h7E01, 64'hFFC0_0000, 0, "R5 mode widen");
    apply(FD, FD, 1, 64'h7FF0_0000_0000_0001, 64'hFFF8_0000_0000_0000, 1, "R5 R6 mode same fmt");
    apply(FH, FH, 1, 64'h7C01, 64'hFE00, 1, "R5 mode half");
    // R6 quiet bit left clear
    apply(FH, FS, 0, 64'h7D00, 64'h7FA0_0000, 1, "R6 signaling stays signaling");
    // R9 junk above source width
    apply(FH, FS, 0, 64'hDEAD_BEEF_0000_7E01, 64'h7FC0_2000, 0, "R9 half junk");
    apply(FS, FD, 0, 64'h1234_5678_7FC0_0001, 64'h7FF8_0000_2000_0000, 0, "R9 single junk");
    apply(FH, FH, 0, 64'hFFFF_FFFF_FFFF_7E00, 64'h7E00, 0, "R9 R8 half pass junk");

    // R10 round trips via the 64-bit format
    for (int k = 0; k < 24; k++) begin
      logic [9:0]  f10;
      logic [22:0] f23;
      logic        sg;
      logic [63:0] narrowW, wideW;
      f10 = 10'(k * 37 + 1);
      if (f10 == 0) f10 = 10'd1;
      sg = k[0];
      narrowW = 64'({sg, 5'h1F, f10});
      wideW   = {sg, 11'h7FF, f10, 42'b0};
      apply(FH, FD, 0, narrowW, wideW, ~f10[9], "R10 half up");
      apply(FD, FH, 0, wideW, narrowW, ~f10[9], "R10 half back");
      f23 = 23'(k * 104729 + 3);
      if (f23 == 0) f23 = 23'd1;
      sg = k[1];
      narrowW = 64'({sg, 8'hFF, f23});
      wideW   = {sg, 11'h7FF, f23, 29'b0};
      apply(FS, FD, 0, narrowW, wideW, ~f23[22], "R10 single up");
      apply(FD, FS, 0, wideW, narrowW, ~f23[22], "R10 single back");
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule